// File: doc/BRIEF.md
# Dataflow Node Stage Scheduler

This controller sits inside one processing element of a dataflow array. It keeps a small kernel table describing the graph nodes mapped to the element and a status table holding one entry per live instance of a node. Each node's work is split into up to four blocks (load, calculate, flow, store). Each block is issued to its own stage unit, so the units run concurrently and up to four different instances can be in the element at once.

Instances are started from a queue of free status entries, one per cycle. The lowest-numbered node that still owes instances and has at least one block goes first. Incoming activations count down a per-instance counter. An instance may reach its calculate block only after its load block has finished and that counter is at zero. When several instances compete for an idle unit, the one with the lowest instance number wins. Completion pulses from the units move an instance to its next present block or retire it. A retired instance returns its entry to the free queue.

The kernel table is written through a configuration port. Rewriting a node clears its started-instance count.

Top module: `dfn_stage_sched`

## Requirements
- R1: Stage codes are 0 load, 1 calculate, 2 flow, 3 store, and mask bit k marks stage k present. An instance visits its present stages in ascending code order and never receives a dispatch for an absent stage. A node whose mask is zero never starts.
- R2: A stage with code 1 or higher is dispatched only when the instance's activation counter is zero. The counter is loaded with the node's configured activation count at start and drops by one for each activation naming that node and instance number. Because stages run in order, a present load must also have been acknowledged first.
- R3: When several instances are eligible for one unit, the lowest instance number wins. Ties go to the lowest status entry index.
- R4: A unit receives at most one dispatch per cycle. It is dispatched only when its idle input was high in the prior cycle and its previous dispatch has been acknowledged, and it never receives dispatches in two consecutive cycles.
- R5: A dispatch carries the stage's configured instruction address, the instance number and the node tag. The operand address is the load base plus entry*16 for load, the store base plus entry*16 for store, and entry*16 alone for calculate and flow.
- R6: An acknowledgement on a unit advances the instance it holds to the next present stage. After the last present stage, the acknowledgement retires the instance and frees its entry.
- R7: Free entries are handed out first-in first-out, starting from 0,1,2,3 after reset, with retired entries appended in retirement order (lower stage code first within one cycle). A node starts instances 0 up to total-1 and then stops. Starts wait while no entry is free.
- R8: An activation that matches no live instance sets err_o, which stays high until reset.
- R9: After reset no dispatch strobe is high and err_o is low.
- R10: The four units run concurrently, so different instances can hold different units at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Kernel table write strobe |
| cfg_node_i | input | 1 | Node slot written |
| cfg_tag_i | input | 8 | Task and node identifier tag |
| cfg_total_i | input | 8 | Number of instances to run |
| cfg_acts_i | input | 4 | Activations expected per instance |
| cfg_mask_i | input | 4 | Present-stage mask |
| cfg_iaddr_i | input | 4x8 | Instruction start address per stage |
| cfg_ld_base_i | input | 12 | Load operand base |
| cfg_st_base_i | input | 12 | Store operand base |
| act_valid_i | input | 1 | Activation arrives |
| act_node_i | input | 1 | Node slot of the activation |
| act_inst_i | input | 8 | Instance number of the activation |
| unit_idle_i | input | 4 | Stage unit ready for work |
| unit_ack_i | input | 4 | Stage unit completion pulse |
| disp_o | output | 4 | Dispatch strobe per unit |
| disp_iaddr_o | output | 4x8 | Instruction address per unit |
| disp_opaddr_o | output | 4x12 | Operand address per unit |
| disp_inst_o | output | 4x8 | Instance number per unit |
| disp_tag_o | output | 4x8 | Node tag per unit |
| err_o | output | 1 | Sticky orphan activation flag |

## Verification
The first pattern runs a four-stage node with three instances beside a calculate-and-flow node without activations. The calculate unit is held busy while activations arrive out of order, so that tie-breaking by entry index, priority by instance number and the wait on a missing activation each show up as a distinct calculate order. A second pattern reconfigures one node as load-and-store with more instances than entries. This exposes the free queue order and entry reuse through the operand addresses. A final activation for a retired instance separates a working orphan check from a silent one.

// File: rtl/dfn_sched_pkg.sv
package dfn_sched_pkg;
  localparam int NSTG = 4;
  typedef enum logic [1:0] {
    STG_LD   = 2'd0,
    STG_CAL  = 2'd1,
    STG_FLOW = 2'd2,
    STG_ST   = 2'd3
  } stage_e;
endpackage

// File: rtl/dfn_sched_pick.sv
module dfn_sched_pick #(
  parameter int N  = 4,
  parameter int KW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][KW-1:0] key_i,
  output logic                 gnt_vld_o,
  output logic [IW-1:0]        gnt_idx_o
);
  logic [KW-1:0] best;

  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    best      = '0;
    for (int i = 0; i < N; i++) begin
      // strict less-than keeps the lowest index on ties
      if (req_i[i] && (!gnt_vld_o || key_i[i] < best)) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IW'(i);
        best      = key_i[i];
      end
    end
  end
endmodule

// File: rtl/dfn_sched_freeq.sv
module dfn_sched_freeq #(
  parameter int DEPTH = 4,
  parameter int NP    = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pop_i,
  output logic [PW-1:0]         head_o,
  output logic                  empty_o,
  input  logic [NP-1:0]         push_i,
  input  logic [NP-1:0][PW-1:0] push_idx_i
);
  logic [DEPTH-1:0][PW-1:0] mem_q;
  logic [PW-1:0]            rptr_q, wptr_q;
  logic [CNTW-1:0]          cnt_q;
  logic [NP-1:0][PW-1:0]    pos;
  logic [CNTW-1:0]          npush;

  always_comb begin
    npush = '0;
    for (int s = 0; s < NP; s++) begin
      pos[s] = wptr_q + PW'(npush);
      if (push_i[s]) npush = npush + 1'b1;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(i);
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= CNTW'(DEPTH);
    end else begin
      for (int s = 0; s < NP; s++)
        if (push_i[s]) mem_q[pos[s]] <= push_idx_i[s];
      wptr_q <= wptr_q + PW'(npush);
      if (pop_i && !empty_o) rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + npush - CNTW'(pop_i && !empty_o);
    end
  end
endmodule

// File: rtl/dfn_stage_sched.sv
module dfn_stage_sched
  import dfn_sched_pkg::*;
#(
  parameter int NUM_NODES = 2,
  parameter int NUM_ENT   = 4,
  parameter int IAW       = 8,
  parameter int AW        = 12,
  parameter int CW        = 8,
  parameter int UW        = 4,
  parameter int TAGW      = 8,
  parameter int CTX_SH    = 4,
  localparam int NW = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int EW = $clog2(NUM_ENT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [NW-1:0]              cfg_node_i,
  input  logic [TAGW-1:0]            cfg_tag_i,
  input  logic [CW-1:0]              cfg_total_i,
  input  logic [UW-1:0]              cfg_acts_i,
  input  logic [NSTG-1:0]            cfg_mask_i,
  input  logic [NSTG-1:0][IAW-1:0]   cfg_iaddr_i,
  input  logic [AW-1:0]              cfg_ld_base_i,
  input  logic [AW-1:0]              cfg_st_base_i,
  input  logic                       act_valid_i,
  input  logic [NW-1:0]              act_node_i,
  input  logic [CW-1:0]              act_inst_i,
  input  logic [NSTG-1:0]            unit_idle_i,
  input  logic [NSTG-1:0]            unit_ack_i,
  output logic [NSTG-1:0]            disp_o,
  output logic [NSTG-1:0][IAW-1:0]   disp_iaddr_o,
  output logic [NSTG-1:0][AW-1:0]    disp_opaddr_o,
  output logic [NSTG-1:0][CW-1:0]    disp_inst_o,
  output logic [NSTG-1:0][TAGW-1:0]  disp_tag_o,
  output logic                       err_o
);
  // kernel table
  logic [NUM_NODES-1:0]                      k_en_q;
  logic [NUM_NODES-1:0][TAGW-1:0]            k_tag_q;
  logic [NUM_NODES-1:0][CW-1:0]              k_total_q, k_started_q;
  logic [NUM_NODES-1:0][UW-1:0]              k_acts_q;
  logic [NUM_NODES-1:0][NSTG-1:0]            k_mask_q;
  logic [NUM_NODES-1:0][NSTG-1:0][IAW-1:0]   k_iaddr_q;
  logic [NUM_NODES-1:0][AW-1:0]              k_ld_q, k_st_q;

  // status table
  logic [NUM_ENT-1:0]            e_vld_q, e_busy_q;
  logic [NUM_ENT-1:0][NW-1:0]    e_node_q;
  logic [NUM_ENT-1:0][CW-1:0]    e_inst_q;
  logic [NUM_ENT-1:0][UW-1:0]    e_up_q;
  logic [NUM_ENT-1:0][1:0]       e_stg_q;

  // per-unit occupancy
  logic [NSTG-1:0]               u_busy_q;
  logic [NSTG-1:0][EW-1:0]       u_ent_q;

  // next present stage strictly above cur (cur = -1 gives the first)
  function automatic logic [2:0] nxt_stg(input logic [NSTG-1:0] mask, input int cur);
    logic [2:0] r;
    r = '0;
    for (int j = NSTG - 1; j >= 0; j--)
      if (mask[j] && j > cur) r = {1'b1, 2'(j)};
    return r;
  endfunction

  // start selection
  logic          fq_empty, start;
  logic [EW-1:0] fq_head;
  logic          st_found;
  logic [NW-1:0] st_node;

  always_comb begin
    st_found = 1'b0;
    st_node  = '0;
    for (int n = NUM_NODES - 1; n >= 0; n--)
      if (k_en_q[n] && k_mask_q[n] != '0 && k_started_q[n] < k_total_q[n]) begin
        st_found = 1'b1;
        st_node  = NW'(n);
      end
  end
  assign start = st_found && !fq_empty;

  // activation match
  logic          act_hit;
  logic [EW-1:0] act_ent;
  always_comb begin
    act_hit = 1'b0;
    act_ent = '0;
    for (int e = 0; e < NUM_ENT; e++)
      if (e_vld_q[e] && e_node_q[e] == act_node_i && e_inst_q[e] == act_inst_i) begin
        act_hit = 1'b1;
        act_ent = EW'(e);
      end
  end

  // per-stage pick and fire
  logic [NSTG-1:0]          fire, gvld;
  logic [NSTG-1:0][EW-1:0]  gidx;
  logic [NSTG-1:0]          ret_push;
  logic [NSTG-1:0][EW-1:0]  ret_idx;
  logic [NSTG-1:0][2:0]     ack_nxt;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic [NUM_ENT-1:0] req;
    always_comb
      for (int e = 0; e < NUM_ENT; e++)
        req[e] = e_vld_q[e] && !e_busy_q[e] && e_stg_q[e] == 2'(s) &&
                 (s == int'(STG_LD) || e_up_q[e] == '0);

    dfn_sched_pick #(.N(NUM_ENT), .KW(CW)) u_pick (
      .req_i    (req),
      .key_i    (e_inst_q),
      .gnt_vld_o(gvld[s]),
      .gnt_idx_o(gidx[s])
    );

    assign fire[s]     = gvld[s] && unit_idle_i[s] && !u_busy_q[s];
    assign ack_nxt[s]  = nxt_stg(k_mask_q[e_node_q[u_ent_q[s]]], s);
    assign ret_push[s] = unit_ack_i[s] && u_busy_q[s] && !ack_nxt[s][2];
    assign ret_idx[s]  = u_ent_q[s];
  end

  dfn_sched_freeq #(.DEPTH(NUM_ENT), .NP(NSTG)) u_freeq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_i     (start),
    .head_o    (fq_head),
    .empty_o   (fq_empty),
    .push_i    (ret_push),
    .push_idx_i(ret_idx)
  );

  // kernel table writes and start counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_en_q      <= '0;
      k_tag_q     <= '0;
      k_total_q   <= '0;
      k_started_q <= '0;
      k_acts_q    <= '0;
      k_mask_q    <= '0;
      k_iaddr_q   <= '0;
      k_ld_q      <= '0;
      k_st_q      <= '0;
    end else begin
      if (start) k_started_q[st_node] <= k_started_q[st_node] + 1'b1;
      if (cfg_we_i) begin
        k_en_q[cfg_node_i]      <= 1'b1;
        k_tag_q[cfg_node_i]     <= cfg_tag_i;
        k_total_q[cfg_node_i]   <= cfg_total_i;
        k_started_q[cfg_node_i] <= '0;
        k_acts_q[cfg_node_i]    <= cfg_acts_i;
        k_mask_q[cfg_node_i]    <= cfg_mask_i;
        k_iaddr_q[cfg_node_i]   <= cfg_iaddr_i;
        k_ld_q[cfg_node_i]      <= cfg_ld_base_i;
        k_st_q[cfg_node_i]      <= cfg_st_base_i;
      end
    end
  end

  // status table and unit state
  logic [2:0] first_stg;
  assign first_stg = nxt_stg(k_mask_q[st_node], -1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_vld_q  <= '0;
      e_busy_q <= '0;
      e_node_q <= '0;
      e_inst_q <= '0;
      e_up_q   <= '0;
      e_stg_q  <= '0;
      u_busy_q <= '0;
      u_ent_q  <= '0;
    end else begin
      for (int s = 0; s < NSTG; s++) begin
        if (unit_ack_i[s] && u_busy_q[s]) begin
          u_busy_q[s] <= 1'b0;
          e_busy_q[u_ent_q[s]] <= 1'b0;
          if (ack_nxt[s][2]) e_stg_q[u_ent_q[s]] <= ack_nxt[s][1:0];
          else               e_vld_q[u_ent_q[s]] <= 1'b0;
        end
        if (fire[s]) begin
          u_busy_q[s]       <= 1'b1;
          u_ent_q[s]        <= gidx[s];
          e_busy_q[gidx[s]] <= 1'b1;
        end
      end
      if (start) begin
        e_vld_q[fq_head]  <= 1'b1;
        e_busy_q[fq_head] <= 1'b0;
        e_node_q[fq_head] <= st_node;
        e_inst_q[fq_head] <= k_started_q[st_node];
        e_up_q[fq_head]   <= k_acts_q[st_node];
        e_stg_q[fq_head]  <= first_stg[1:0];
      end
      if (act_valid_i && act_hit && e_up_q[act_ent] != '0)
        e_up_q[act_ent] <= e_up_q[act_ent] - 1'b1;
    end
  end

  // registered dispatch outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_o        <= '0;
      disp_iaddr_o  <= '0;
      disp_opaddr_o <= '0;
      disp_inst_o   <= '0;
      disp_tag_o    <= '0;
      err_o         <= 1'b0;
    end else begin
      for (int s = 0; s < NSTG; s++) begin
        disp_o[s] <= fire[s];
        if (fire[s]) begin
          disp_iaddr_o[s] <= k_iaddr_q[e_node_q[gidx[s]]][s];
          disp_inst_o[s]  <= e_inst_q[gidx[s]];
          disp_tag_o[s]   <= k_tag_q[e_node_q[gidx[s]]];
          unique case (stage_e'(s))
            STG_LD:  disp_opaddr_o[s] <= k_ld_q[e_node_q[gidx[s]]] + (AW'(gidx[s]) << CTX_SH);
            STG_ST:  disp_opaddr_o[s] <= k_st_q[e_node_q[gidx[s]]] + (AW'(gidx[s]) << CTX_SH);
            default: disp_opaddr_o[s] <= AW'(gidx[s]) << CTX_SH;
          endcase
        end
      end
      if (act_valid_i && !act_hit) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dfn_stage_sched_chk.sv
module dfn_stage_sched_chk #(
  parameter int NSTG = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSTG-1:0] unit_idle_i,
  input logic [NSTG-1:0] disp_o,
  input logic            act_valid_i,
  input logic            act_hit,
  input logic            err_o
);
  for (genvar s = 0; s < NSTG; s++) begin : g_u
    assert_idle_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_o[s] |-> $past(unit_idle_i[s]));
    assert_no_back2back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_o[s] |=> !disp_o[s]);
  end

  assert_orphan_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_i && !act_hit) |=> err_o);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind dfn_stage_sched dfn_stage_sched_chk #(.NSTG(4)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unit_idle_i(unit_idle_i),
  .disp_o     (disp_o),
  .act_valid_i(act_valid_i),
  .act_hit    (act_hit),
  .err_o      (err_o)
);

// File: tb/dfn_stage_sched_test.sv
module dfn_stage_sched_test;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic                cfg_we_i = 1'b0;
  logic [0:0]          cfg_node_i = '0;
  logic [7:0]          cfg_tag_i = '0, cfg_total_i = '0;
  logic [3:0]          cfg_acts_i = '0, cfg_mask_i = '0;
  logic [NS-1:0][7:0]  cfg_iaddr_i = '0;
  logic [11:0]         cfg_ld_base_i = '0, cfg_st_base_i = '0;
  logic                act_valid_i = 1'b0;
  logic [0:0]          act_node_i = '0;
  logic [7:0]          act_inst_i = '0;
  logic [NS-1:0]       unit_idle_i = '0, unit_ack_i = '0;
  logic [NS-1:0]       disp_o;
  logic [NS-1:0][7:0]  disp_iaddr_o, disp_inst_o, disp_tag_o;
  logic [NS-1:0][11:0] disp_opaddr_o;
  logic                err_o;

  dfn_stage_sched uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_node_i(cfg_node_i), .cfg_tag_i(cfg_tag_i),
    .cfg_total_i(cfg_total_i), .cfg_acts_i(cfg_acts_i), .cfg_mask_i(cfg_mask_i),
    .cfg_iaddr_i(cfg_iaddr_i), .cfg_ld_base_i(cfg_ld_base_i), .cfg_st_base_i(cfg_st_base_i),
    .act_valid_i(act_valid_i), .act_node_i(act_node_i), .act_inst_i(act_inst_i),
    .unit_idle_i(unit_idle_i), .unit_ack_i(unit_ack_i),
    .disp_o(disp_o), .disp_iaddr_o(disp_iaddr_o), .disp_opaddr_o(disp_opaddr_o),
    .disp_inst_o(disp_inst_o), .disp_tag_o(disp_tag_o), .err_o(err_o)
  );

  typedef struct {
    logic [7:0]  inst, iaddr, tag;
    logic [11:0] opaddr;
    int          ent;
    bit          last;
  } item_t;

  item_t q0[$], q1[$], q2[$], q3[$];
  int    ret_q[$];
  int    errors = 0, checks = 0;
  int    seen[NS];
  int    outstanding = 0, max_out = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int s, input int ent, input int inst, input logic [7:0] iaddr,
                          input logic [7:0] tag, input logic [11:0] base, input bit last);
    item_t it;
    it.inst = 8'(inst); it.iaddr = iaddr; it.tag = tag; it.ent = ent; it.last = last;
    it.opaddr = base + 12'(ent * 16);
    case (s)
      0: q0.push_back(it);
      1: q1.push_back(it);
      2: q2.push_back(it);
      default: q3.push_back(it);
    endcase
  endtask

  task automatic cfg(input int node, input logic [7:0] tag, input int total, input int acts,
                     input logic [3:0] mask, input logic [7:0] ia0, input logic [11:0] ldb,
                     input logic [11:0] stb);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_node_i = 1'(node); cfg_tag_i = tag; cfg_total_i = 8'(total);
    cfg_acts_i = 4'(acts); cfg_mask_i = mask; cfg_ld_base_i = ldb; cfg_st_base_i = stb;
    for (int k = 0; k < NS; k++) cfg_iaddr_i[k] = ia0 + 8'(k * 16);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic act(input int node, input int inst);
    @(negedge clk);
    act_valid_i = 1'b1; act_node_i = 1'(node); act_inst_i = 8'(inst);
    @(negedge clk);
    act_valid_i = 1'b0;
  endtask

  // stage unit models: acknowledge three cycles after a dispatch
  for (genvar s = 0; s < NS; s++) begin : g_unit
    initial forever begin
      @(negedge clk);
      if (disp_o[s]) begin
        repeat (3) @(negedge clk);
        unit_ack_i[s] = 1'b1;
        @(negedge clk);
        unit_ack_i[s] = 1'b0;
      end
    end
  end

  // monitor: pop and compare each dispatch
  initial forever begin
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      if (disp_o[s]) begin
        item_t it;
        bit    have;
        string r;
        seen[s]++;
        outstanding++;
        have = 1;
        case (s)
          0: if (q0.size() > 0) it = q0.pop_front(); else have = 0;
          1: if (q1.size() > 0) it = q1.pop_front(); else have = 0;
          2: if (q2.size() > 0) it = q2.pop_front(); else have = 0;
          default: if (q3.size() > 0) it = q3.pop_front(); else have = 0;
        endcase
        r = (s == 1) ? "R2/R3" : "R1";
        chk(have, "R1", $sformatf("unexpected dispatch stage %0d", s), 1, 0);
        if (have) begin
          chk(disp_inst_o[s] == it.inst, r, $sformatf("inst stage %0d", s), disp_inst_o[s], it.inst);
          chk(disp_iaddr_o[s] == it.iaddr, "R5", $sformatf("iaddr stage %0d", s), disp_iaddr_o[s], it.iaddr);
          chk(disp_tag_o[s] == it.tag, "R5", $sformatf("tag stage %0d", s), disp_tag_o[s], it.tag);
          chk(disp_opaddr_o[s] == it.opaddr, "R7", $sformatf("opaddr stage %0d", s), disp_opaddr_o[s], it.opaddr);
          if (it.last) ret_q.push_back(it.ent);
        end
      end
      if (unit_ack_i[s]) outstanding--;
    end
    if (outstanding > max_out) max_out = outstanding;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(disp_o == '0, "R9", "dispatch after reset", disp_o, 0);
    chk(err_o == 1'b0, "R9", "err after reset", err_o, 0);

    // phase 1 expectations (free entries 0..3 in order)
    for (int i = 0; i < 3; i++) push_exp(0, i, i, 8'h10, 8'h11, 12'h100, 0);
    push_exp(1, 0, 0, 8'h20, 8'h11, 12'h000, 0); // R3 tie: entry 0 beats entry 3
    push_exp(1, 3, 0, 8'h60, 8'h12, 12'h000, 0);
    push_exp(1, 1, 1, 8'h20, 8'h11, 12'h000, 0);
    push_exp(1, 2, 2, 8'h20, 8'h11, 12'h000, 0); // R2: held until its activation
    push_exp(2, 0, 0, 8'h30, 8'h11, 12'h000, 0);
    push_exp(2, 3, 0, 8'h70, 8'h12, 12'h000, 1); // R1: node without store retires here
    push_exp(2, 1, 1, 8'h30, 8'h11, 12'h000, 0);
    push_exp(2, 2, 2, 8'h30, 8'h11, 12'h000, 0);
    for (int i = 0; i < 3; i++) push_exp(3, i, i, 8'h40, 8'h11, 12'h200, 1);

    cfg(0, 8'h11, 3, 1, 4'b1111, 8'h10, 12'h100, 12'h200);
    cfg(1, 8'h12, 1, 0, 4'b0110, 8'h50, 12'h180, 12'h280);
    unit_idle_i = 4'b1101;
    repeat (30) @(negedge clk);
    chk(seen[0] == 3, "R2", "loads done, calc held", seen[0], 3);
    chk(seen[1] == 0, "R4", "calc unit not idle, no dispatch", seen[1], 0);
    act(0, 1);
    act(0, 0);
    chk(err_o == 1'b0, "R8", "matched activations keep err low", err_o, 0);
    unit_idle_i = 4'b1111;
    repeat (60) @(negedge clk);
    chk(seen[1] == 3, "R2", "calc waits for last activation", seen[1], 3);
    act(0, 2);
    repeat (60) @(negedge clk);
    chk(seen[1] == 4 && seen[2] == 4 && seen[3] == 3, "R6", "phase 1 dispatch counts",
        seen[1] + seen[2] + seen[3], 11);
    chk(max_out >= 2, "R10", "units busy at once", max_out, 2);
    chk(ret_q.size() == 4, "R6", "phase 1 retirements", ret_q.size(), 4);

    // phase 2: load+store node, more instances than entries
    for (int i = 0; i < 5; i++) begin
      int e;
      e = (ret_q.size() == 4) ? ret_q[(i == 4) ? 0 : i] : 0;
      push_exp(0, e, i, 8'h90, 8'h22, 12'h300, 0);
      push_exp(3, e, i, 8'hC0, 8'h22, 12'h380, 1);
    end
    cfg(1, 8'h22, 5, 0, 4'b1001, 8'h90, 12'h300, 12'h380);
    repeat (120) @(negedge clk);
    chk(seen[0] == 8, "R7", "node stops after total instances", seen[0], 8);
    chk(seen[3] == 8, "R1", "store follows load with stages skipped", seen[3], 8);
    chk(seen[1] == 4 && seen[2] == 4, "R1", "absent stages not dispatched", seen[1] + seen[2], 8);
    chk(q0.size() + q1.size() + q2.size() + q3.size() == 0, "R7", "expected queue drained",
        q0.size() + q1.size() + q2.size() + q3.size(), 0);
    chk(err_o == 1'b0, "R8", "no error before orphan", err_o, 0);

    // R8 orphan activation for a retired instance
    act(0, 0);
    chk(err_o == 1'b1, "R8", "orphan activation flagged", err_o, 1);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R8", "err stays set", err_o, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule